// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a four-register command window that lets a host reach a separate 32-bit register space it cannot address directly. The host loads a target address and, for a store, a data word. It then writes a command word that requests either a read or a write. The bridge performs exactly one access on a downstream port that uses a request/done handshake. When that access completes, the bridge raises an acknowledge flag in the command register. The host polls for the flag, collects read results, and then writes zero to the command register to return the bridge to idle.

The window occupies four word offsets starting at a configurable base inside a larger host address region. Host accesses to any other offset have no effect and read back zero. Commands that are malformed, that arrive while an access is still pending, or that name an address outside the legal target range never reach the downstream port.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset, the command, address, write-data and result registers all read 0, and neither downstream request is asserted.
- R2: The window decodes four words relative to base `WIN_BASE` (default 0x400): command at +0x0, target address at +0x4, result at +0x8, write data at +0xC. The address and write-data words read back what the host last wrote. The result word is read-only, so host writes to it change nothing.
- R3: A command word whose bits [1:0] equal 01 starts a read, and 10 starts a write. The matching downstream request stays high, with a stable address, until `dn_done` is sampled high. It drops on the following edge, and the two requests are never high together.
- R4: The acknowledge flag is bit 2 of the command register, and reads return {29'b0, ack, wr, rd}. For a read, the target value is already in the result register in the first cycle that ack reads 1.
- R5: A write command stores the write-data word into the target register named by the address word.
- R6: The downstream access uses the address and write-data values held at the edge where the command is accepted. Host writes to those registers made while the access is in flight do not change it.
- R7: Writing zero to the command register while it is acknowledged returns the bridge to idle, and the whole command register then reads 0.
- R8: In idle, a command word with bits [1:0] equal to 00 or 11 starts nothing, issues no downstream request, and leaves the command register at 0.
- R9: While an access is in flight or acknowledged, any nonzero command write is ignored. The command register, result word and downstream activity are unchanged by it.
- R10: A target address above `TGT_MAX` (0xFFF) or not a multiple of 4 completes at once with ack set and no downstream request. A read of such an address returns 0 in the result register, and a write is discarded.
- R11: Writing zero while an access is in flight makes the command register read 0 at once. The downstream access still runs to completion, and the bridge then returns to idle without setting ack.
- R12: Host writes to offsets outside the four window words have no effect, and host reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte offset within the host region |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for `host_addr` (combinational) |
| dn_rd_req | output | 1 | Downstream read request |
| dn_wr_req | output | 1 | Downstream write request |
| dn_addr | output | TGT_AW | Downstream target address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, valid with `dn_done` |
| dn_done | input | 1 | Downstream completion |

## Verification
Reads are swept over 64 target addresses, with a downstream latency that cycles from zero to three extra cycles. The expected words are computed arithmetically, so the sweep tells a correct data capture apart from a capture taken one cycle early or late. Writes are swept over 32 addresses and then read back through the bridge, which separates a correct store from one that goes to the wrong address or carries the wrong data. Targeted patterns cover the remaining behaviour: address and data changed during a long access, malformed command codes, commands issued while busy or acknowledged, clears issued mid-flight, misaligned and out-of-range addresses, and offsets outside the window. In each case the bench counts downstream completions, which tells a suppressed access apart from one that silently ran.

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge #(
  parameter int DATA_W = 32,
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] WIN_BASE = 12'h400,
  parameter int TGT_AW = 32,
  parameter logic [TGT_AW-1:0] TGT_MAX = 32'h0000_0FFF,
  parameter int STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               dn_rd_req,
  output logic               dn_wr_req,
  output logic [TGT_AW-1:0]  dn_addr,
  output logic [DATA_W-1:0]  dn_wdata,
  input  logic [DATA_W-1:0]  dn_rdata,
  input  logic               dn_done
);
  localparam logic [HOST_AW-1:0] OFS_CMD = WIN_BASE;
  localparam logic [HOST_AW-1:0] OFS_ADR = WIN_BASE + HOST_AW'(4);
  localparam logic [HOST_AW-1:0] OFS_RES = WIN_BASE + HOST_AW'(8);
  localparam logic [HOST_AW-1:0] OFS_WDT = WIN_BASE + HOST_AW'(12);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACK} state_t;

  state_t            state;
  logic [TGT_AW-1:0] addr_q, lat_addr;
  logic [DATA_W-1:0] wdata_q, lat_wdata, res_q;
  logic              op_rd, op_wr, drop_q;

  logic sel_cmd, cmd_zero, good_cmd, addr_ok, ack_vis;
  logic [DATA_W-1:0] cmd_view;

  assign sel_cmd  = host_we && (host_addr == OFS_CMD);
  assign cmd_zero = (host_wdata == '0);
  assign good_cmd = host_wdata[0] ^ host_wdata[1];
  assign addr_ok  = (addr_q <= TGT_MAX) && ((addr_q % TGT_AW'(STRIDE)) == '0);
  assign ack_vis  = (state == S_ACK);

  assign cmd_view = (state == S_IDLE || drop_q) ? '0
                  : {{(DATA_W-3){1'b0}}, ack_vis, op_wr, op_rd};

  always_comb begin
    case (host_addr)
      OFS_CMD: host_rdata = cmd_view;
      OFS_ADR: host_rdata = DATA_W'(addr_q);
      OFS_RES: host_rdata = res_q;
      OFS_WDT: host_rdata = wdata_q;
      default: host_rdata = '0;
    endcase
  end

  assign dn_rd_req = (state == S_BUSY) && op_rd;
  assign dn_wr_req = (state == S_BUSY) && op_wr;
  assign dn_addr   = lat_addr;
  assign dn_wdata  = lat_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdata_q <= '0;
    end else if (host_we) begin
      if (host_addr == OFS_ADR) addr_q <= TGT_AW'(host_wdata);
      if (host_addr == OFS_WDT) wdata_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_rd <= 1'b0;
      op_wr <= 1'b0;
      drop_q <= 1'b0;
      res_q <= '0;
      lat_addr <= '0;
      lat_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (sel_cmd && good_cmd) begin
            op_rd <= host_wdata[0];
            op_wr <= host_wdata[1];
            lat_addr <= addr_q;
            lat_wdata <= wdata_q;
            if (addr_ok) begin
              state <= S_BUSY;
            end else begin
              state <= S_ACK;
              if (host_wdata[0]) res_q <= '0;
            end
          end
        end
        S_BUSY: begin
          if (dn_done) begin
            if (op_rd) res_q <= dn_rdata;
            state <= (drop_q || (sel_cmd && cmd_zero)) ? S_IDLE : S_ACK;
            drop_q <= 1'b0;
          end else if (sel_cmd && cmd_zero) begin
            drop_q <= 1'b1;
          end
        end
        S_ACK: begin
          if (sel_cmd && cmd_zero) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module irb_checker #(
  parameter int DATA_W = 32,
  parameter int HOST_AW = 12,
  parameter logic [HOST_AW-1:0] WIN_BASE = 12'h400,
  parameter int TGT_AW = 32,
  parameter logic [TGT_AW-1:0] TGT_MAX = 32'h0000_0FFF,
  parameter int STRIDE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               dn_rd_req,
  input logic               dn_wr_req,
  input logic [TGT_AW-1:0]  dn_addr,
  input logic               dn_done,
  input logic               ack_vis
);
  logic any_req, cmd_wr;
  assign any_req = dn_rd_req || dn_wr_req;
  assign cmd_wr  = host_we && (host_addr == WIN_BASE);

  p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_rd_req && dn_wr_req));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !dn_done) |=> ($stable(dn_addr) && $stable(dn_rd_req) && $stable(dn_wr_req)));

  p_req_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && dn_done) |=> !any_req);

  p_legal_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> ((dn_addr <= TGT_MAX) && ((dn_addr % TGT_AW'(STRIDE)) == '0)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata == '0 && !any_req) |=> !ack_vis);

  p_bad_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !any_req && !ack_vis && (host_wdata[0] == host_wdata[1])) |=> (!any_req && !ack_vis));

  p_no_req_when_acked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vis |-> !any_req);
endmodule

bind indirect_reg_bridge irb_checker #(
  .DATA_W(DATA_W), .HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE),
  .TGT_AW(TGT_AW), .TGT_MAX(TGT_MAX), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .dn_rd_req(dn_rd_req), .dn_wr_req(dn_wr_req),
  .dn_addr(dn_addr), .dn_done(dn_done), .ack_vis(ack_vis)
);

// File: tb/tb_indirect_reg_bridge.sv
module tb_indirect_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        dn_rd_req, dn_wr_req;
  logic [31:0] dn_addr, dn_wdata;
  logic [31:0] dn_rdata = '0;
  logic        dn_done = 1'b0;

  int tests = 0, fails = 0, cycles = 0, txn_cnt = 0, cur_lat = 0, cnt = 0;
  logic [31:0] mem [1024];

  localparam logic [11:0] A_CMD = 12'h400, A_ADR = 12'h404, A_RES = 12'h408, A_WDT = 12'h40C;

  always #5 clk = ~clk;

  indirect_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dn_rd_req(dn_rd_req),
    .dn_wr_req(dn_wr_req), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata), .dn_done(dn_done)
  );

  function automatic logic [31:0] pat(int i);
    return (i * 32'h0101_0101) ^ 32'hA5C3_0000 ^ (i << 20);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (dn_done) begin
      dn_done <= 1'b0;
      cnt = 0;
    end else if (dn_rd_req || dn_wr_req) begin
      if (cnt >= cur_lat) begin
        dn_done <= 1'b1;
        if (dn_rd_req) dn_rdata <= mem[dn_addr[11:2]];
        else mem[dn_addr[11:2]] = dn_wdata;
        txn_cnt++;
        cnt = 0;
      end else cnt++;
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic hrd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; #1;
    d = host_rdata;
  endtask

  task automatic wait_ack(output logic [31:0] c, output int ok);
    ok = 0;
    for (int k = 0; k < 50; k++) begin
      hrd(A_CMD, c);
      if (c[2]) begin ok = 1; break; end
    end
  endtask

  task automatic do_read(logic [31:0] a, int lat, output logic [31:0] d, output int ok);
    logic [31:0] c;
    cur_lat = lat;
    hwr(A_ADR, a);
    hwr(A_CMD, 32'h1);
    wait_ack(c, ok);
    hrd(A_RES, d);
    hwr(A_CMD, 32'h0);
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] v, int lat, output int ok);
    logic [31:0] c;
    cur_lat = lat;
    hwr(A_WDT, v);
    hwr(A_ADR, a);
    hwr(A_CMD, 32'h2);
    wait_ack(c, ok);
    hwr(A_CMD, 32'h0);
  endtask

  initial begin
    logic [31:0] r, r2, c;
    int ok, t0;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    hrd(A_CMD, r); check("R1 cmd", r, 0);
    hrd(A_ADR, r); check("R1 addr", r, 0);
    hrd(A_RES, r); check("R1 result", r, 0);
    hrd(A_WDT, r); check("R1 wdata", r, 0);
    check("R1 no req", {30'b0, dn_rd_req, dn_wr_req}, 0);

    // R2 register offsets
    hwr(A_ADR, 32'h0000_0ABC); hrd(A_ADR, r); check("R2 addr readback", r, 32'h0000_0ABC);
    hwr(A_WDT, 32'hDEAD_BEEF); hrd(A_WDT, r); check("R2 wdata readback", r, 32'hDEAD_BEEF);
    hwr(A_RES, 32'h1234_5678); hrd(A_RES, r); check("R2 result read-only", r, 0);

    // R3 R4 read sweep with variable latency
    for (int i = 0; i < 64; i++) begin
      int idx = (i * 37) % 1024;
      logic [31:0] ca;
      cur_lat = i % 4;
      hwr(A_ADR, idx * 4);
      hwr(A_CMD, 32'h1);
      wait_ack(ca, ok);
      hrd(A_RES, r);
      check("R4 ack/cmd word on read", ca, 32'h5);
      check("R4 read data at ack", r, pat(idx));
      hwr(A_CMD, 32'h0);
    end

    // R5 write sweep, then read back through bridge
    for (int i = 0; i < 32; i++) begin
      int idx = (i * 53 + 7) % 1024;
      logic [31:0] v = 32'h5A00_0000 + i * 32'h0001_0203;
      do_write(idx * 4, v, (i + 1) % 4, ok);
      check("R5 write acked", ok, 1);
      check("R5 target stored", mem[idx], v);
      do_read(idx * 4, 2, r, ok);
      check("R5 read back", r, v);
    end

    // R6 values latched at command time
    cur_lat = 8;
    hwr(A_WDT, 32'hCAFE_0001);
    hwr(A_ADR, 32'h100);
    hwr(A_CMD, 32'h2);
    hwr(A_ADR, 32'h200);
    hwr(A_WDT, 32'hBAD0_BAD0);
    wait_ack(c, ok);
    hwr(A_CMD, 32'h0);
    check("R6 latched addr/data", mem[32'h100 >> 2], 32'hCAFE_0001);
    check("R6 other addr untouched", mem[32'h200 >> 2], pat(32'h200 >> 2));

    // R7 clear returns 0
    do_read(32'h10, 0, r, ok);
    hrd(A_CMD, r); check("R7 cmd zero after clear", r, 0);

    // R8 malformed commands
    t0 = txn_cnt;
    hwr(A_ADR, 32'h20);
    hwr(A_CMD, 32'h3);
    repeat (4) @(posedge clk);
    hrd(A_CMD, r); check("R8 both bits", r, 0);
    hwr(A_CMD, 32'h4);
    repeat (4) @(posedge clk);
    hrd(A_CMD, r); check("R8 neither bit", r, 0);
    check("R8 no downstream access", txn_cnt, t0);

    // R9 command ignored while acked and while busy
    cur_lat = 1;
    hwr(A_ADR, 32'h40);
    hwr(A_CMD, 32'h1);
    wait_ack(c, ok);
    t0 = txn_cnt;
    hwr(A_ADR, 32'h44);
    hwr(A_CMD, 32'h2);
    repeat (4) @(posedge clk);
    hrd(A_CMD, r); check("R9 cmd unchanged when acked", r, 32'h5);
    hrd(A_RES, r); check("R9 result unchanged", r, pat(16));
    check("R9 no extra access when acked", txn_cnt, t0);
    hwr(A_CMD, 32'h0);
    cur_lat = 6;
    hwr(A_ADR, 32'h48);
    hwr(A_CMD, 32'h1);
    hwr(A_CMD, 32'h2);
    wait_ack(c, ok);
    check("R9 busy-time cmd ignored", c, 32'h5);
    hrd(A_RES, r); check("R9 busy read result", r, pat(18));
    check("R9 single access", txn_cnt, t0 + 1);
    hwr(A_CMD, 32'h0);

    // R10 illegal addresses
    t0 = txn_cnt;
    hwr(A_RES, 0);
    do_read(32'h44, 0, r, ok);
    t0 = txn_cnt;
    do_read(32'h1000, 0, r, ok);
    check("R10 out-of-range read acked", ok, 1);
    check("R10 out-of-range read zero", r, 0);
    do_read(32'h46, 0, r, ok);
    check("R10 misaligned read zero", r, 0);
    do_write(32'h1004, 32'hFFFF_FFFF, 0, ok);
    check("R10 bad write acked", ok, 1);
    do_write(32'h0FFF, 32'hFFFF_FFFF, 0, ok);
    check("R10 no downstream access", txn_cnt, t0);
    check("R10 top word untouched", mem[1023], pat(1023));
    do_read(32'hFFC, 1, r, ok);
    check("R10 highest legal addr", r, pat(1023));

    // R11 clear while busy
    t0 = txn_cnt;
    cur_lat = 6;
    hwr(A_ADR, 32'h80);
    hwr(A_CMD, 32'h1);
    hwr(A_CMD, 32'h0);
    hrd(A_CMD, r); check("R11 cmd zero at once", r, 0);
    repeat (12) @(posedge clk);
    hrd(A_CMD, r); check("R11 no ack after finish", r, 0);
    check("R11 access completed", txn_cnt, t0 + 1);
    do_read(32'h84, 1, r, ok);
    check("R11 next transaction", r, pat(33));

    // R12 offsets outside the window
    t0 = txn_cnt;
    hwr(12'h000, 32'h1);
    hwr(12'h004, 32'h0000_0F00);
    repeat (4) @(posedge clk);
    check("R12 no access from foreign offset", txn_cnt, t0);
    hrd(A_ADR, r); check("R12 addr reg untouched", r, 32'h84);
    hwr(12'h410, 32'h7777_7777);
    hrd(12'h410, r); check("R12 foreign read zero", r, 0);
    hrd(12'h3FC, r2); check("R12 below-base read zero", r2, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule